// File: doc/BRIEF.md
# Vector Load/Store Displacement Rewriter

This block produces the per-element displacement for a vectorised memory access. The front end hands it the raw immediate fields of the instruction, the encoding form, the vector addressing mode and the current loop position. It returns a 32-bit displacement, in the encoding of the instruction's immediate slot, together with a flag that tells the issue logic whether that value replaces the encoded immediate.

Three addressing modes rewrite the immediate. Unit-stride adds the element offset times the access width. Element-stride multiplies the immediate by the element offset. Shift mode scales the immediate by the element offset and then shifts it left by a register value. For loads the element offset comes from the source step, or from the remapped step when remapping is on. For stores it always comes from the destination step. A DS-form instruction gets the result back in word units. Register reads and the final address add belong to neighbouring logic. The result is registered and appears one cycle after the input strobe.

Top module: `ldst_disp_rewriter`

## Requirements
- R1: With `mode`=3 (shift), the immediate is `sv_fld` sign-extended from 11 bits. The result is (immediate × element offset) shifted left by `rc_value`, truncated to 32 bits. It is zero when `rc_value` ≥ 32.
- R2: In modes 1 and 2, the immediate is `d_fld` sign-extended from 16 bits when `form_ds`=0. When `form_ds`=1 it is {`ds_fld`,2'b00} sign-extended from 16 bits.
- R3: When `is_store`=0 (load), the element offset is `src_step`×(`sub_len`+1)+`sub_step`. When `remap_act`=1 it is `remap_step` instead.
- R4: When `is_store`=1, the element offset is `dst_step`×(`sub_len`+1)+`sub_step`, and `remap_act` and `remap_step` have no effect.
- R5: With `mode`=1 (unit-stride), the result is immediate + offset × (1 << `width_code`), truncated to 32 bits. `width_code` 0..3 selects 1, 2, 4 or 8 bytes.
- R6: With `mode`=2 (element-stride), the result is immediate × offset, truncated to 32 bits.
- R7: When a rewrite occurs and `form_ds`=1, `disp` is the 32-bit result shifted right logically by 2.
- R8: With `mode`=0 (normal), `replace` is 0. `disp` carries the original immediate in slot encoding: `d_fld` sign-extended from 16 bits for D-form, or `ds_fld` sign-extended from 14 bits for DS-form.
- R9: With `vec_mode`=0, `replace` is 0 and `disp` is the original immediate exactly as in R8, whatever the mode.
- R10: `out_valid` pulses on the clock edge after an edge with `in_valid`=1. `disp` and `replace` update only on such edges and hold otherwise. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| vec_mode | input | 1 | Instruction runs in vector mode |
| form_ds | input | 1 | 1 = DS-form, 0 = D-form |
| mode | input | 2 | 0 normal, 1 unit-stride, 2 element-stride, 3 shift |
| is_store | input | 1 | 1 = store, 0 = load |
| d_fld | input | 16 | D-form immediate field |
| ds_fld | input | 14 | DS-form immediate field |
| sv_fld | input | 11 | Shift-mode immediate field |
| src_step | input | STEP_W | Source element step |
| dst_step | input | STEP_W | Destination element step |
| sub_step | input | 2 | Sub-vector step |
| sub_len | input | 2 | Sub-vector length minus one |
| remap_act | input | 1 | Remapping active |
| remap_step | input | STEP_W | Remapped source step |
| width_code | input | 2 | log2 of access width in bytes |
| rc_value | input | 32 | Shift amount read from the RC register |
| out_valid | output | 1 | Result strobe |
| replace | output | 1 | Displacement replaces the immediate |
| disp | output | 32 | Rewritten or passed-through displacement |

## Verification
Every result is due on the first rising edge after the strobe that carried its inputs. The bench drives inputs on a falling edge and compares `out_valid`, `replace` and `disp` with its model on the next falling edge, which is half a cycle after the result registers load. Idle cycles follow some requests, and at each one the bench expects the previous `disp` and `replace` to be held and `out_valid` to be low.

// File: rtl/ldst_disp_pkg.sv
package ldst_disp_pkg;
   typedef enum logic [1:0] {
      LM_NORMAL = 2'd0,
      LM_UNIT   = 2'd1,
      LM_ELEM   = 2'd2,
      LM_SHIFT  = 2'd3
   } ldst_mode_e;

   localparam int DISP_W  = 32;
   localparam int DFLD_W  = 16;
   localparam int DSFLD_W = 14;
   localparam int SVFLD_W = 11;
   localparam int SUB_W   = 2;
   localparam int WC_W    = 2;
endpackage

// File: rtl/lsd_imm_extract.sv
module lsd_imm_extract
   import ldst_disp_pkg::*;
#(
   parameter int OUT_W = DISP_W
) (
   input  logic [DFLD_W-1:0]  d_fld,
   input  logic [DSFLD_W-1:0] ds_fld,
   input  logic [SVFLD_W-1:0] sv_fld,
   input  logic               form_ds,
   input  logic               shift_mode,
   output logic [OUT_W-1:0]   imm_ext,
   output logic [OUT_W-1:0]   imm_orig
);
   localparam int DS_PAD = DFLD_W - DSFLD_W;

   logic [DFLD_W-1:0] ds_scaled;
   logic [OUT_W-1:0]  sx_d, sx_ds_bytes, sx_ds_words, sx_sv;

   always_comb begin
      ds_scaled   = {ds_fld, {DS_PAD{1'b0}}};
      sx_d        = OUT_W'($signed(d_fld));
      sx_ds_bytes = OUT_W'($signed(ds_scaled));
      sx_ds_words = OUT_W'($signed(ds_fld));
      sx_sv       = OUT_W'($signed(sv_fld));
   end

   always_comb begin
      if (shift_mode)   imm_ext = sx_sv;
      else if (form_ds) imm_ext = sx_ds_bytes;
      else              imm_ext = sx_d;
      imm_orig = form_ds ? sx_ds_words : sx_d;
   end
endmodule

// File: rtl/lsd_elem_offset.sv
module lsd_elem_offset
   import ldst_disp_pkg::*;
#(
   parameter int STEP_W = 7,
   parameter int OFF_W  = STEP_W + SUB_W + 1
) (
   input  logic [STEP_W-1:0] src_step,
   input  logic [STEP_W-1:0] dst_step,
   input  logic [SUB_W-1:0]  sub_step,
   input  logic [SUB_W-1:0]  sub_len,
   input  logic              is_store,
   input  logic              remap_act,
   input  logic [STEP_W-1:0] remap_step,
   output logic [OFF_W-1:0]  offset
);
   logic [STEP_W-1:0] base_step;
   logic [OFF_W-1:0]  group_len;
   logic [OFF_W-1:0]  linear;

   always_comb begin
      base_step = is_store ? dst_step : src_step;
      group_len = OFF_W'(sub_len) + OFF_W'(1);
      linear    = OFF_W'(base_step) * group_len + OFF_W'(sub_step);
      // remapped step applies to loads only
      if (!is_store && remap_act) offset = OFF_W'(remap_step);
      else                        offset = linear;
   end
endmodule

// File: rtl/lsd_disp_calc.sv
module lsd_disp_calc
   import ldst_disp_pkg::*;
#(
   parameter int OUT_W     = DISP_W,
   parameter int OFF_W     = 10,
   parameter int RC_W      = 32,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic [OUT_W-1:0] imm_ext,
   input  logic [OUT_W-1:0] imm_orig,
   input  logic [OFF_W-1:0] offset,
   input  ldst_mode_e       mode,
   input  logic             vec_mode,
   input  logic             form_ds,
   input  logic [WC_W-1:0]  width_code,
   input  logic [RC_W-1:0]  rc_value,
   output logic [OUT_W-1:0] disp_nxt,
   output logic             replace_nxt
);
   localparam int SH_W = $clog2(OUT_W);

   logic [OUT_W-1:0] off_x, prod, unit_res, shift_res, raw_res, ds_res;
   logic             rc_big;

   always_comb begin
      off_x    = OUT_W'(offset);
      prod     = imm_ext * off_x;
      unit_res = imm_ext + (off_x << width_code);
   end

   if (RC_W > SH_W) begin : g_rc_wide
      assign rc_big = |rc_value[RC_W-1:SH_W];
   end else begin : g_rc_narrow
      assign rc_big = 1'b0;
   end

   if (LOG_SHIFT) begin : g_log_shift
      logic [OUT_W-1:0] stage [SH_W+1];
      assign stage[0] = prod;
      for (genvar i = 0; i < SH_W; i++) begin : g_stage
         assign stage[i+1] = rc_value[i] ? (stage[i] << (1 << i)) : stage[i];
      end
      assign shift_res = rc_big ? '0 : stage[SH_W];
   end else begin : g_flat_shift
      assign shift_res = rc_big ? '0 : (prod << rc_value[SH_W-1:0]);
   end

   always_comb begin
      unique case (mode)
         LM_UNIT:  raw_res = unit_res;
         LM_ELEM:  raw_res = prod;
         LM_SHIFT: raw_res = shift_res;
         default:  raw_res = imm_orig;
      endcase
      ds_res      = raw_res >> 2;
      replace_nxt = vec_mode && (mode != LM_NORMAL);
      if (!replace_nxt) disp_nxt = imm_orig;
      else if (form_ds) disp_nxt = ds_res;
      else              disp_nxt = raw_res;
   end
endmodule

// File: rtl/ldst_disp_rewriter.sv
module ldst_disp_rewriter
   import ldst_disp_pkg::*;
#(
   parameter int STEP_W    = 7,
   parameter int RC_W      = 32,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               vec_mode,
   input  logic               form_ds,
   input  logic [1:0]         mode,
   input  logic               is_store,
   input  logic [15:0]        d_fld,
   input  logic [13:0]        ds_fld,
   input  logic [10:0]        sv_fld,
   input  logic [STEP_W-1:0]  src_step,
   input  logic [STEP_W-1:0]  dst_step,
   input  logic [1:0]         sub_step,
   input  logic [1:0]         sub_len,
   input  logic               remap_act,
   input  logic [STEP_W-1:0]  remap_step,
   input  logic [1:0]         width_code,
   input  logic [RC_W-1:0]    rc_value,
   output logic               out_valid,
   output logic               replace,
   output logic [31:0]        disp
);
   localparam int OFF_W = STEP_W + SUB_W + 1;

   if (STEP_W < 1 || STEP_W > 16) begin : g_bad_step
      $error("ldst_disp_rewriter: STEP_W must be 1..16");
   end
   if (RC_W < 6) begin : g_bad_rc
      $error("ldst_disp_rewriter: RC_W must be at least 6");
   end

   ldst_mode_e       mode_e;
   logic [DISP_W-1:0] imm_ext, imm_orig, disp_nxt;
   logic [OFF_W-1:0]  offset;
   logic              replace_nxt;

   assign mode_e = ldst_mode_e'(mode);

   lsd_imm_extract #(.OUT_W(DISP_W)) u_imm (
      .d_fld(d_fld), .ds_fld(ds_fld), .sv_fld(sv_fld),
      .form_ds(form_ds), .shift_mode(mode_e == LM_SHIFT),
      .imm_ext(imm_ext), .imm_orig(imm_orig)
   );

   lsd_elem_offset #(.STEP_W(STEP_W), .OFF_W(OFF_W)) u_off (
      .src_step(src_step), .dst_step(dst_step), .sub_step(sub_step),
      .sub_len(sub_len), .is_store(is_store), .remap_act(remap_act),
      .remap_step(remap_step), .offset(offset)
   );

   lsd_disp_calc #(.OUT_W(DISP_W), .OFF_W(OFF_W), .RC_W(RC_W),
                   .LOG_SHIFT(LOG_SHIFT)) u_calc (
      .imm_ext(imm_ext), .imm_orig(imm_orig), .offset(offset),
      .mode(mode_e), .vec_mode(vec_mode), .form_ds(form_ds),
      .width_code(width_code), .rc_value(rc_value),
      .disp_nxt(disp_nxt), .replace_nxt(replace_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         replace   <= 1'b0;
         disp      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            replace <= replace_nxt;
            disp    <= disp_nxt;
         end
      end
   end
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        vec_mode,
   input logic        form_ds,
   input logic [1:0]  mode,
   input logic        out_valid,
   input logic        replace,
   input logic [31:0] disp
);
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(disp) && $stable(replace)));
   p_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == 2'd0) |=> !replace);
   p_scalar_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !vec_mode) |=> !replace);
   p_ds_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vec_mode && mode != 2'd0 && form_ds) |=> (disp[31:30] == 2'b00));
endmodule

bind ldst_disp_rewriter lsd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_mode(vec_mode),
   .form_ds(form_ds), .mode(mode), .out_valid(out_valid),
   .replace(replace), .disp(disp)
);

// File: tb/sim_ldst_disp_rewriter.sv
module sim_ldst_disp_rewriter;
   localparam int STEP_W = 7;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic vec_mode = 1'b0, form_ds = 1'b0, is_store = 1'b0, remap_act = 1'b0;
   logic [1:0] mode = '0, sub_step = '0, sub_len = '0, width_code = '0;
   logic [15:0] d_fld = '0;
   logic [13:0] ds_fld = '0;
   logic [10:0] sv_fld = '0;
   logic [STEP_W-1:0] src_step = '0, dst_step = '0, remap_step = '0;
   logic [31:0] rc_value = '0;
   logic out_valid, replace;
   logic [31:0] disp;

   int checks = 0, fails = 0;
   logic        exp_rep = 1'b0;
   logic [31:0] exp_disp = '0;

   always #10 clk = ~clk;

   ldst_disp_rewriter #(.STEP_W(STEP_W)) u0 (.*);

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void model(output logic rep, output logic [31:0] res);
      longint imm, off, v;
      logic [31:0] r;
      logic [31:0] orig;
      orig = form_ds ? 32'(longint'($signed(ds_fld))) : 32'(longint'($signed(d_fld)));
      if (mode == 2'd3) imm = (sv_fld >= 1024) ? longint'(sv_fld) - 2048 : longint'(sv_fld);
      else begin
         v = form_ds ? longint'(ds_fld) * 4 : longint'(d_fld);
         imm = (v >= 32768) ? v - 65536 : v;
      end
      if (is_store) off = longint'(dst_step) * (sub_len + 1) + sub_step;
      else if (remap_act) off = longint'(remap_step);
      else off = longint'(src_step) * (sub_len + 1) + sub_step;
      case (mode)
         2'd1: v = imm + off * (longint'(1) << width_code);
         2'd2: v = imm * off;
         2'd3: v = (rc_value >= 32) ? 0 : ((imm * off) << rc_value);
         default: v = 0;
      endcase
      r = v[31:0];
      if (form_ds) r = r >> 2;
      rep = vec_mode && (mode != 2'd0);
      res = rep ? r : orig;
   endfunction

   task automatic fire(string tag);
      string t;
      logic rep;
      logic [31:0] res;
      t = tag;
      if (t == "") begin
         if (!vec_mode) t = "R9";
         else case (mode)
            2'd0: t = "R8";
            2'd1: t = "R5";
            2'd2: t = "R6";
            default: t = "R1";
         endcase
      end
      model(rep, res);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp_rep = rep;
      exp_disp = res;
      chk("R10 out_valid", 32'(out_valid), 32'd1);
      chk({t, " replace"}, 32'(replace), 32'(exp_rep));
      chk({t, " disp"}, disp, exp_disp);
   endtask

   task automatic idle();
      @(negedge clk);
      chk("R10 idle out_valid", 32'(out_valid), 32'd0);
      chk("R10 hold replace", 32'(replace), 32'(exp_rep));
      chk("R10 hold disp", disp, exp_disp);
   endtask

   initial begin
      #4000000;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", 32'(out_valid), 32'd0);
      chk("R10 reset replace", 32'(replace), 32'd0);
      chk("R10 reset disp", disp, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: scalar, unit-stride mode requested but ignored
      vec_mode = 0; mode = 2'd1; d_fld = 16'hFFF0; src_step = 7'd5; fire("R9");
      // R8: normal mode DS-form passes sign-extended 14-bit field
      vec_mode = 1; mode = 2'd0; form_ds = 1; ds_fld = 14'h3FFE; fire("R8");
      idle();
      // R2/R5: D-form unit stride, negative immediate
      form_ds = 0; mode = 2'd1; d_fld = 16'h8000; src_step = 7'd3; sub_len = 2'd1;
      sub_step = 2'd1; width_code = 2'd3; fire("R2");
      // R2/R7: DS-form element stride
      form_ds = 1; mode = 2'd2; ds_fld = 14'h0005; src_step = 7'd7; sub_len = 0;
      sub_step = 0; fire("R7");
      // R7: negative DS result shifted logically
      ds_fld = 14'h3FFF; fire("R7");
      // R3: remap on load
      form_ds = 0; mode = 2'd2; d_fld = 16'd12; remap_act = 1; remap_step = 7'd9;
      src_step = 7'd2; fire("R3");
      // R4: store ignores remap
      is_store = 1; dst_step = 7'd4; sub_len = 2'd3; sub_step = 2'd2; fire("R4");
      idle();
      // R1: shift mode, negative sv field
      is_store = 0; remap_act = 0; mode = 2'd3; sv_fld = 11'h7FD; src_step = 7'd6;
      sub_len = 0; sub_step = 0; rc_value = 32'd4; fire("R1");
      rc_value = 32'd31; fire("R1");
      rc_value = 32'd32; fire("R1");
      rc_value = 32'h8000_0002; fire("R1");
      form_ds = 1; rc_value = 32'd3; fire("R1");

      for (int i = 0; i < 400; i++) begin
         vec_mode = ($urandom % 5) != 0;
         form_ds = 1'($urandom); mode = 2'($urandom); is_store = 1'($urandom);
         d_fld = 16'($urandom); ds_fld = 14'($urandom); sv_fld = 11'($urandom);
         src_step = 7'($urandom); dst_step = 7'($urandom); remap_step = 7'($urandom);
         sub_step = 2'($urandom); sub_len = 2'($urandom); remap_act = 1'($urandom);
         width_code = 2'($urandom); rc_value = 32'($urandom % 40);
         fire("");
         if (($urandom % 4) == 0) idle();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule